// File: doc/BRIEF.md
# Byte ALU with Sixteen-Entry Register File

This block is the execution datapath of a small 8-bit controller. It keeps sixteen 8-bit general registers together with a carry flag and a zero flag. Each cycle in which `en` is high, it carries out one already-decoded operation. The result is written back into the destination register, and/or the flags are updated.

The sequencer in front of the block presents several fields from the instruction word:

- the 6-bit operation code;
- the destination and source register numbers;
- the low byte of the word, which is the immediate;
- the external data byte that INPUT and FETCH load.

Bit 0 of the operation code chooses the second operand:

- 0 selects the immediate;
- 1 selects the source register.

The block continuously shows the destination register on `dst_value` and the source register on `index_addr`. The port and scratchpad logic outside the block uses these as write data and as an indexed address. The memory, the I/O decode, instruction fetch and branching all sit outside the block.

All inputs are plain level signals sampled on the rising edge of `clk`. There is no handshake. A cycle with `en` low is simply a cycle in which nothing changes.

Top module: `byte_alu_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, carry and zero are both cleared to 0 after that edge.
- R2: Operand B is `imm` when `op_code[0]` is 0, and the register selected by `src_sel` when it is 1. LOAD (`op_code[5:1]` = 00000) writes operand B into the destination register and leaves both flags unchanged.
- R3: AND (00101), OR (00110) and XOR (00111) write the bitwise result, clear carry, and set zero when the result is 0.
- R4: ADD (01100) writes the sum of the destination register and operand B. ADDCY (01101) also adds the carry flag. In both cases carry becomes the carry out of bit 7 and zero flags a zero byte.
- R5: SUB (01110) writes the destination register minus operand B. SUBCY (01111) also subtracts the carry flag. In both cases carry becomes the borrow and zero flags a zero byte.
- R6: TEST (01001) and COMP (01010) leave the destination register unchanged.
  - TEST sets zero from the AND of the two operands, and sets carry to the odd parity of that AND.
  - COMP sets zero and carry (borrow) as SUB would.
- R7: The left shifts use `op_code` = 100000, with the sub-code in `imm[3:1]` and the fill bit in `imm[0]`. Carry receives the old bit 7 and zero flags a zero result.
  - 000 shifts carry in at bit 0.
  - 001 rotates left.
  - 010 repeats bit 0.
  - 011 shifts in the fill bit.
- R8: The right shifts use the same code, sub-code and fill fields as R7. Carry receives the old bit 0 and zero flags a zero result.
  - 100 shifts carry in at bit 7.
  - 101 repeats bit 7.
  - 110 rotates right.
  - 111 shifts in the fill bit.
- R9: INPUT (00010) and FETCH (00011) write `ext_data` into the destination register and leave both flags unchanged.
- R10: OUTPUT (10110) and STORE (10111) write no register and no flag. `dst_value` always shows the destination register and `index_addr` always shows the source register.
- R11: A cycle with `en` low changes no register and no flag.
- R12: Any operation code not listed above, including 100001, changes no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset of the flags |
| en | input | 1 | Executes the presented operation at this edge |
| op_code | input | 6 | Decoded operation code, bit 0 picks immediate or register operand |
| dst_sel | input | 4 | Destination register number |
| src_sel | input | 4 | Source register number |
| imm | input | 8 | Immediate byte; bits 3:1 shift sub-code, bit 0 fill bit |
| ext_data | input | 8 | Byte loaded by INPUT and FETCH |
| dst_value | output | 8 | Current destination register contents |
| index_addr | output | 8 | Current source register contents (indexed address) |
| carry | output | 1 | Carry/borrow flag |
| zero | output | 1 | Zero flag |

## Verification
The write-back properties compare `dst_value` one cycle after an operation. They assume that `dst_sel` still names the same register in that cycle, and they hold vacuously when it does not. The flag properties assume that reset is asserted at the first edge, so that both flags start from a known value. The bench changes every input only on the falling edge. It keeps the register numbers unchanged between an operation and the read that checks it, and it forces the carry to a known value before each carry-dependent case.

// File: rtl/alu_rf_pkg.sv
package alu_rf_pkg;
  // Operation groups, opcode bits [5:1]; bit 0 selects the operand source.
  localparam logic [4:0] GRP_LOAD   = 5'b00000;
  localparam logic [4:0] GRP_INPUT  = 5'b00010;
  localparam logic [4:0] GRP_FETCH  = 5'b00011;
  localparam logic [4:0] GRP_AND    = 5'b00101;
  localparam logic [4:0] GRP_OR     = 5'b00110;
  localparam logic [4:0] GRP_XOR    = 5'b00111;
  localparam logic [4:0] GRP_TEST   = 5'b01001;
  localparam logic [4:0] GRP_COMP   = 5'b01010;
  localparam logic [4:0] GRP_ADD    = 5'b01100;
  localparam logic [4:0] GRP_ADDCY  = 5'b01101;
  localparam logic [4:0] GRP_SUB    = 5'b01110;
  localparam logic [4:0] GRP_SUBCY  = 5'b01111;
  localparam logic [4:0] GRP_SHIFT  = 5'b10000;

  typedef enum logic [2:0] {
    SH_LEFT_CARRY  = 3'b000,
    SH_LEFT_ROT    = 3'b001,
    SH_LEFT_REP    = 3'b010,
    SH_LEFT_FILL   = 3'b011,
    SH_RIGHT_CARRY = 3'b100,
    SH_RIGHT_REP   = 3'b101,
    SH_RIGHT_ROT   = 3'b110,
    SH_RIGHT_FILL  = 3'b111
  } shift_mode_e;
endpackage

// File: rtl/alu_regbank.sv
module alu_regbank #(
  parameter int W  = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [W-1:0]  rd_data_a,
  output logic [W-1:0]  rd_data_b
);
  localparam int NREGS = 1 << AW;

  logic [W-1:0] bank [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [W-1:0] q;
    logic         hit;
    assign hit = we && (wr_addr == AW'(g));
    always_ff @(posedge clk) begin
      if (hit) q <= wr_data;
    end
    assign bank[g] = q;
  end

  assign rd_data_a = bank[rd_addr_a];
  assign rd_data_b = bank[rd_addr_b];
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_rf_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [2:0]   mode,
  input  logic         fill,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);
  always_comb begin
    unique case (shift_mode_e'(mode))
      SH_LEFT_CARRY:  {cout, res} = {a, cin};
      SH_LEFT_ROT:    {cout, res} = {a, a[W-1]};
      SH_LEFT_REP:    {cout, res} = {a, a[0]};
      SH_LEFT_FILL:   {cout, res} = {a, fill};
      SH_RIGHT_CARRY: {res, cout} = {cin, a};
      SH_RIGHT_REP:   {res, cout} = {a[W-1], a};
      SH_RIGHT_ROT:   {res, cout} = {a[0], a};
      default:        {res, cout} = {fill, a};
    endcase
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_rf_pkg::*;
#(
  parameter int W    = 8,
  parameter int OP_W = 6
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [W-1:0]    ext,
  input  logic [3:0]      sh_field,
  input  logic            cin,
  output logic [W-1:0]    res,
  output logic            wr_reg,
  output logic            upd_flags,
  output logic            c_nxt,
  output logic            z_nxt
);
  logic [W:0]   sum;
  logic [W-1:0] sh_res;
  logic         sh_c;
  logic [W-1:0] anded;

  alu_shift #(.W(W)) u_shift (
    .a(a), .mode(sh_field[3:1]), .fill(sh_field[0]), .cin(cin),
    .res(sh_res), .cout(sh_c)
  );

  assign anded = a & b;

  always_comb begin
    res       = b;
    wr_reg    = 1'b0;
    upd_flags = 1'b0;
    c_nxt     = cin;
    sum       = '0;
    unique case (op[OP_W-1:1])
      GRP_LOAD: begin
        res = b; wr_reg = 1'b1;
      end
      GRP_INPUT, GRP_FETCH: begin
        res = ext; wr_reg = 1'b1;
      end
      GRP_AND: begin
        res = anded; wr_reg = 1'b1; upd_flags = 1'b1; c_nxt = 1'b0;
      end
      GRP_OR: begin
        res = a | b; wr_reg = 1'b1; upd_flags = 1'b1; c_nxt = 1'b0;
      end
      GRP_XOR: begin
        res = a ^ b; wr_reg = 1'b1; upd_flags = 1'b1; c_nxt = 1'b0;
      end
      GRP_TEST: begin
        res = anded; upd_flags = 1'b1; c_nxt = ^anded;
      end
      GRP_ADD, GRP_ADDCY: begin
        sum = {1'b0, a} + {1'b0, b}
            + (W+1)'((op[OP_W-1:1] == GRP_ADDCY) ? cin : 1'b0);
        res = sum[W-1:0]; c_nxt = sum[W];
        wr_reg = 1'b1; upd_flags = 1'b1;
      end
      GRP_SUB, GRP_SUBCY, GRP_COMP: begin
        sum = {1'b0, a} - {1'b0, b}
            - (W+1)'((op[OP_W-1:1] == GRP_SUBCY) ? cin : 1'b0);
        res = sum[W-1:0]; c_nxt = sum[W];
        wr_reg = (op[OP_W-1:1] != GRP_COMP); upd_flags = 1'b1;
      end
      GRP_SHIFT: begin
        if (!op[0]) begin
          res = sh_res; c_nxt = sh_c; wr_reg = 1'b1; upd_flags = 1'b1;
        end
      end
      default: begin
        wr_reg = 1'b0; upd_flags = 1'b0;
      end
    endcase
  end

  assign z_nxt = (res == '0);
endmodule

// File: rtl/byte_alu_regfile.sv
module byte_alu_regfile #(
  parameter int W    = 8,
  parameter int AW   = 4,
  parameter int OP_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [OP_W-1:0] op_code,
  input  logic [AW-1:0]   dst_sel,
  input  logic [AW-1:0]   src_sel,
  input  logic [W-1:0]    imm,
  input  logic [W-1:0]    ext_data,
  output logic [W-1:0]    dst_value,
  output logic [W-1:0]    index_addr,
  output logic            carry,
  output logic            zero
);
  logic [W-1:0] opnd_b;
  logic [W-1:0] alu_res;
  logic         alu_wr;
  logic         alu_flags;
  logic         c_nxt;
  logic         z_nxt;
  logic         carry_q;
  logic         zero_q;

  alu_regbank #(.W(W), .AW(AW)) u_bank (
    .clk(clk),
    .we(en && alu_wr),
    .wr_addr(dst_sel),
    .wr_data(alu_res),
    .rd_addr_a(dst_sel),
    .rd_addr_b(src_sel),
    .rd_data_a(dst_value),
    .rd_data_b(index_addr)
  );

  assign opnd_b = op_code[0] ? index_addr : imm;

  alu_core #(.W(W), .OP_W(OP_W)) u_core (
    .op(op_code), .a(dst_value), .b(opnd_b), .ext(ext_data),
    .sh_field(imm[3:0]), .cin(carry_q),
    .res(alu_res), .wr_reg(alu_wr), .upd_flags(alu_flags),
    .c_nxt(c_nxt), .z_nxt(z_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
      zero_q  <= 1'b0;
    end else if (en && alu_flags) begin
      carry_q <= c_nxt;
      zero_q  <= z_nxt;
    end
  end

  assign carry = carry_q;
  assign zero  = zero_q;
endmodule

// File: rtl/alu_rf_chk.sv
module alu_rf_chk #(
  parameter int W    = 8,
  parameter int AW   = 4,
  parameter int OP_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            en,
  input logic [OP_W-1:0] op_code,
  input logic [AW-1:0]   dst_sel,
  input logic [W-1:0]    imm,
  input logic [W-1:0]    dst_value,
  input logic            carry,
  input logic            zero
);
  logic [W-1:0] add_prev;
  assign add_prev = W'(dst_value + imm);

  p_reset_clears_r1: assert property (@(posedge clk)
    rst |=> (!carry && !zero));

  p_idle_keeps_flags_r11: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(carry) && $stable(zero)));

  p_load_keeps_flags_r2: assert property (@(posedge clk) disable iff (rst)
    (en && op_code[OP_W-1:1] == 5'b00000) |=> ($stable(carry) && $stable(zero)));

  p_load_imm_writes_r2: assert property (@(posedge clk) disable iff (rst)
    (en && op_code == 6'b000000) |=> (!$stable(dst_sel) || dst_value == $past(imm)));

  p_ext_keeps_flags_r9: assert property (@(posedge clk) disable iff (rst)
    (en && op_code[OP_W-1:2] == 4'b0001) |=> ($stable(carry) && $stable(zero)));

  p_test_comp_no_write_r6: assert property (@(posedge clk) disable iff (rst)
    (en && (op_code[OP_W-1:1] == 5'b01001 || op_code[OP_W-1:1] == 5'b01010))
    |=> (!$stable(dst_sel) || $stable(dst_value)));

  p_out_store_no_write_r10: assert property (@(posedge clk) disable iff (rst)
    (en && op_code[OP_W-1:2] == 4'b1011)
    |=> (!$stable(dst_sel) || ($stable(dst_value) && $stable(carry) && $stable(zero))));

  p_add_zero_flag_r4: assert property (@(posedge clk) disable iff (rst)
    (en && op_code == 6'b011000) |=> (zero == ($past(add_prev) == '0)));
endmodule

bind byte_alu_regfile alu_rf_chk #(.W(W), .AW(AW), .OP_W(OP_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .op_code(op_code), .dst_sel(dst_sel),
  .imm(imm), .dst_value(dst_value), .carry(carry), .zero(zero)
);

// File: tb/byte_alu_regfile_test.sv
`timescale 1ns/1ps
module byte_alu_regfile_test;
  localparam logic [5:0] OP_LOAD = 6'h00, OP_INPUT = 6'h04, OP_FETCH = 6'h06,
    OP_AND = 6'h0A, OP_OR = 6'h0C, OP_XOR = 6'h0E, OP_TEST = 6'h12,
    OP_COMP = 6'h14, OP_ADD = 6'h18, OP_ADDCY = 6'h1A, OP_SUB = 6'h1C,
    OP_SUBCY = 6'h1E, OP_SHIFT = 6'h20, OP_OUTPUT = 6'h2C, OP_STORE = 6'h2E,
    OP_NOP = 6'h3F;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [5:0] op_code = OP_NOP;
  logic [3:0] dst_sel = '0;
  logic [3:0] src_sel = '0;
  logic [7:0] imm = '0;
  logic [7:0] ext_data = '0;
  logic [7:0] dst_value, index_addr;
  logic       carry, zero;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  byte_alu_regfile uut (
    .clk(clk), .rst(rst), .en(en), .op_code(op_code), .dst_sel(dst_sel),
    .src_sel(src_sel), .imm(imm), .ext_data(ext_data), .dst_value(dst_value),
    .index_addr(index_addr), .carry(carry), .zero(zero)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [5:0] op, input logic [3:0] d, input logic [3:0] s,
                      input logic [7:0] i, input logic e = 1'b1);
    @(negedge clk);
    op_code = op; dst_sel = d; src_sel = s; imm = i; en = e;
    @(posedge clk);
    #1;
    en = 1'b0; op_code = OP_NOP;
  endtask

  task automatic peek(input logic [3:0] r, output logic [7:0] v);
    dst_sel = r;
    #1;
    v = dst_value;
  endtask

  task automatic set_carry(input logic v);
    step(OP_LOAD, 4'd15, 4'd0, 8'h00);
    if (v) step(OP_SUB, 4'd15, 4'd0, 8'h01);
    else   step(OP_AND, 4'd15, 4'd0, 8'h00);
  endtask

  task automatic t_reset;
    chk("R1 carry after reset", {7'd0, carry}, 8'h00);
    chk("R1 zero after reset", {7'd0, zero}, 8'h00);
  endtask

  task automatic t_load;
    logic [7:0] v;
    set_carry(1'b1);
    step(OP_LOAD, 4'd1, 4'd0, 8'h3C);
    step(OP_LOAD, 4'd2, 4'd0, 8'hC5);
    step(OP_LOAD | 6'd1, 4'd3, 4'd1, 8'hFF);
    peek(4'd1, v); chk("R2 load imm", v, 8'h3C);
    peek(4'd3, v); chk("R2 load reg form", v, 8'h3C);
    chk("R2 flags kept", {6'd0, carry, zero}, 8'h02);
  endtask

  task automatic t_logic;
    logic [7:0] v;
    set_carry(1'b1);
    step(OP_AND, 4'd1, 4'd0, 8'h0F);
    peek(4'd1, v); chk("R3 and imm", v, 8'h0C);
    chk("R3 and flags", {6'd0, carry, zero}, 8'h00);
    step(OP_OR | 6'd1, 4'd3, 4'd2, 8'h00);
    peek(4'd3, v); chk("R3 or reg", v, 8'hFD);
    step(OP_XOR | 6'd1, 4'd3, 4'd3, 8'h00);
    peek(4'd3, v); chk("R3 xor self", v, 8'h00);
    chk("R3 xor zero flag", {6'd0, carry, zero}, 8'h01);
  endtask

  task automatic t_add;
    logic [7:0] v;
    step(OP_LOAD, 4'd4, 4'd0, 8'hF0);
    step(OP_ADD, 4'd4, 4'd0, 8'h20);
    peek(4'd4, v); chk("R4 add wrap", v, 8'h10);
    chk("R4 add carry", {6'd0, carry, zero}, 8'h02);
    step(OP_LOAD, 4'd5, 4'd0, 8'h01);
    step(OP_ADDCY, 4'd5, 4'd0, 8'h01);
    peek(4'd5, v); chk("R4 addcy with carry", v, 8'h03);
    chk("R4 addcy flags", {6'd0, carry, zero}, 8'h00);
    step(OP_LOAD, 4'd5, 4'd0, 8'h80);
    step(OP_ADD, 4'd5, 4'd0, 8'h80);
    chk("R4 add to zero flags", {6'd0, carry, zero}, 8'h03);
  endtask

  task automatic t_sub;
    logic [7:0] v;
    step(OP_LOAD, 4'd6, 4'd0, 8'h10);
    step(OP_SUB, 4'd6, 4'd0, 8'h20);
    peek(4'd6, v); chk("R5 sub borrow", v, 8'hF0);
    chk("R5 sub flags", {6'd0, carry, zero}, 8'h02);
    step(OP_SUBCY, 4'd6, 4'd0, 8'h00);
    peek(4'd6, v); chk("R5 subcy", v, 8'hEF);
    chk("R5 subcy flags", {6'd0, carry, zero}, 8'h00);
  endtask

  task automatic t_test_comp;
    logic [7:0] v;
    step(OP_TEST, 4'd1, 4'd0, 8'h04);
    chk("R6 test odd parity", {6'd0, carry, zero}, 8'h02);
    step(OP_TEST, 4'd1, 4'd0, 8'h30);
    chk("R6 test zero", {6'd0, carry, zero}, 8'h01);
    step(OP_COMP, 4'd1, 4'd0, 8'h0C);
    chk("R6 comp equal", {6'd0, carry, zero}, 8'h01);
    step(OP_COMP, 4'd1, 4'd0, 8'h0D);
    chk("R6 comp below", {6'd0, carry, zero}, 8'h02);
    peek(4'd1, v); chk("R6 dest unchanged", v, 8'h0C);
  endtask

  task automatic shift_case(input string tag, input logic [7:0] val, input logic cin,
                            input logic [2:0] mode, input logic fill,
                            input logic [7:0] exp, input logic expc);
    logic [7:0] v;
    step(OP_LOAD, 4'd7, 4'd0, val);
    set_carry(cin);
    step(OP_SHIFT, 4'd7, 4'd0, {4'd0, mode, fill});
    peek(4'd7, v); chk(tag, v, exp);
    chk(tag, {6'd0, carry, zero}, {6'd0, expc, exp == 8'h00});
  endtask

  task automatic t_shift_left;
    shift_case("R7 sla", 8'h81, 1'b1, 3'b000, 1'b0, 8'h03, 1'b1);
    shift_case("R7 rl", 8'h80, 1'b0, 3'b001, 1'b0, 8'h01, 1'b1);
    shift_case("R7 slx", 8'h41, 1'b0, 3'b010, 1'b0, 8'h83, 1'b0);
    shift_case("R7 sl0", 8'h81, 1'b1, 3'b011, 1'b0, 8'h02, 1'b1);
    shift_case("R7 sl0 zero", 8'h80, 1'b0, 3'b011, 1'b0, 8'h00, 1'b1);
    shift_case("R7 sl1", 8'h00, 1'b0, 3'b011, 1'b1, 8'h01, 1'b0);
  endtask

  task automatic t_shift_right;
    shift_case("R8 sra", 8'h02, 1'b1, 3'b100, 1'b0, 8'h81, 1'b0);
    shift_case("R8 srx", 8'h85, 1'b0, 3'b101, 1'b0, 8'hC2, 1'b1);
    shift_case("R8 rr", 8'h01, 1'b0, 3'b110, 1'b0, 8'h80, 1'b1);
    shift_case("R8 sr0", 8'h80, 1'b1, 3'b111, 1'b0, 8'h40, 1'b0);
    shift_case("R8 sr1", 8'h00, 1'b0, 3'b111, 1'b1, 8'h80, 1'b0);
  endtask

  task automatic t_ext;
    logic [7:0] v;
    set_carry(1'b1);
    ext_data = 8'hA5;
    step(OP_INPUT, 4'd9, 4'd0, 8'h00);
    peek(4'd9, v); chk("R9 input", v, 8'hA5);
    ext_data = 8'h00;
    step(OP_FETCH | 6'd1, 4'd10, 4'd1, 8'h00);
    peek(4'd10, v); chk("R9 fetch", v, 8'h00);
    chk("R9 flags kept", {6'd0, carry, zero}, 8'h02);
  endtask

  task automatic t_out_store;
    logic [7:0] v;
    step(OP_OUTPUT | 6'd1, 4'd1, 4'd2, 8'h55);
    step(OP_STORE, 4'd1, 4'd2, 8'h55);
    src_sel = 4'd2;
    peek(4'd1, v); chk("R10 no write", v, 8'h0C);
    chk("R10 index addr", index_addr, 8'hC5);
    chk("R10 flags kept", {6'd0, carry, zero}, 8'h02);
  endtask

  task automatic t_idle;
    logic [7:0] v;
    step(OP_ADD, 4'd1, 4'd0, 8'hF4, 1'b0);
    peek(4'd1, v); chk("R11 enable low", v, 8'h0C);
    chk("R11 flags", {6'd0, carry, zero}, 8'h02);
  endtask

  task automatic t_unused;
    logic [7:0] v;
    step(6'h3E, 4'd1, 4'd0, 8'hF4);
    step(6'h21, 4'd1, 4'd0, 8'h00);
    peek(4'd1, v); chk("R12 unused opcode", v, 8'h0C);
    chk("R12 flags", {6'd0, carry, zero}, 8'h02);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_load();
    t_logic();
    t_add();
    t_sub();
    t_test_comp();
    t_shift_left();
    t_shift_right();
    t_ext();
    t_out_store();
    t_idle();
    t_unused();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired got=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule